// File: doc/BRIEF.md
# Configurable GPIO Bank with Edge Interrupts

This block is a bank of general-purpose pins. Six per-pin configuration words, each one bit per pin, set how each pin behaves. A pin is either an input or an output. An input pin passes through a two-flop synchronizer. It can be inverted, and a rising edge on its inverted level can latch a sticky interrupt flag. An output pin drives its stored level, drives only low (open-drain), or is released completely (3-state). All the enabled flags are ORed into one interrupt line.

Pin 0 can instead carry the output of an external timer. While timer mode is on, the configuration words have no control over that pin.

Software reaches the bank through a simple synchronous port:
- A write is one `wr_en` cycle carrying `addr` and `wdata`.
- A read is one `rd_en` cycle. `rdata` appears with `rvalid` on the next cycle.
- Reading the status word returns the latched flags. The flags that were returned clear one cycle later. A flag set in the meantime survives.

Top module: `pinbank_top`

## Requirements
- R1: After reset, the interrupt-enable, level, 3-state, invert and open-drain words are 0, and the direction word is all ones (every pin an input). `pad_oe` is 0 and `irq` is 0.
- R2: The words sit at these addresses: interrupt enable at 0, 3-state at 2, invert at 3, direction at 4, open-drain at 5. A write with `wr_en` stores `wdata` into the addressed word. A read with `rd_en` returns that word on `rdata`, with `rvalid` high for exactly the next cycle.
- R3: Reading address 1 (the level word) returns different sources per pin. A pin whose direction bit is 1 (input) returns its synchronized pad level XOR its invert bit. Any other pin returns its stored level bit.
- R4: A pin with direction 0, 3-state 0 and open-drain 0 drives `pad_oe`=1 and `pad_out` equal to its level bit. The pad outputs follow a register write by one cycle.
- R5: A pin with direction 0, 3-state 0 and open-drain 1 gives `pad_out`=0 and `pad_oe` equal to the inverse of its level bit. It is never driven high.
- R6: A pin with direction 1, or with 3-state 1, has `pad_oe`=0 whatever its open-drain and level bits are.
- R7: A 0-to-1 change of an input pin's inverted level sets that pin's sticky flag, provided its interrupt-enable bit is 1. A 1-to-0 change sets nothing, and neither does a change on a pin whose enable bit is 0.
- R8: Reading address 6 returns the sticky flags. The flags returned are cleared one cycle after the read. Address 6 ignores writes.
- R9: `irq` is the registered OR of the sticky flags ANDed with the interrupt-enable word. Clearing an enable bit drops `irq` without losing the flag.
- R10: Writing the invert or direction word never sets a sticky flag by itself, even when it flips an input pin's level from 0 to 1.
- R11: With `timer_sel`=1, pin 0 drives `pad_oe[0]`=1 and `pad_out[0]` equal to `timer_out`, one cycle later. Pin 0 then sets no sticky flag.
- R12: Address 7 reads as 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | NPIN | Write data |
| rdata | output | NPIN | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |
| pad_in | input | NPIN | Raw pad input levels (asynchronous) |
| pad_out | output | NPIN | Pad output values |
| pad_oe | output | NPIN | Pad output enables |
| timer_out | input | 1 | Timer waveform for pin 0 |
| timer_sel | input | 1 | Selects timer drive on pin 0 |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest condition to reach is a configuration write that lifts an input pin's inverted level from 0 to 1. Without care, such a write would fire a false interrupt. Only the one-cycle history reload can stop it.

To reach it, the stimulus first holds a pad high with its interrupt enabled. It then sets the pin's invert bit, so the level falls, and clears the bit again, so the level rises. After that it checks that `irq` stays low and that the status word reads 0. The same style of sequence covers pin 0 while it is under timer control: the pad is toggled there and the status word must stay clear.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_IEN  = 3'd0,
    SEL_LVL  = 3'd1,
    SEL_TRI  = 3'd2,
    SEL_INV  = 3'd3,
    SEL_DIR  = 3'd4,
    SEL_ODR  = 3'd5,
    SEL_STAT = 3'd6,
    SEL_NONE = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int NPIN   = 16,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] d,
  output logic [NPIN-1:0] q
);
  logic [NPIN-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
  import pinbank_pkg::*;
#(
  parameter int NPIN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPIN-1:0]   wdata,
  input  logic [NPIN-1:0]   lvl_rd,
  input  logic [NPIN-1:0]   sticky,
  output logic [NPIN-1:0]   ien_q,
  output logic [NPIN-1:0]   lvl_q,
  output logic [NPIN-1:0]   tri_q,
  output logic [NPIN-1:0]   inv_q,
  output logic [NPIN-1:0]   dir_q,
  output logic [NPIN-1:0]   odr_q,
  output logic              cfg_chg,
  output logic [NPIN-1:0]   clr_mask,
  output logic [NPIN-1:0]   rdata,
  output logic              rvalid
);
  reg_sel_e        sel;
  logic [NPIN-1:0] rd_mux;

  assign sel = reg_sel_e'(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q   <= '0;
      lvl_q   <= '0;
      tri_q   <= '0;
      inv_q   <= '0;
      dir_q   <= '1;
      odr_q   <= '0;
      cfg_chg <= 1'b0;
    end else begin
      cfg_chg <= wr_en && (sel == SEL_INV || sel == SEL_DIR);
      if (wr_en) begin
        case (sel)
          SEL_IEN: ien_q <= wdata;
          SEL_LVL: lvl_q <= wdata;
          SEL_TRI: tri_q <= wdata;
          SEL_INV: inv_q <= wdata;
          SEL_DIR: dir_q <= wdata;
          SEL_ODR: odr_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (sel)
      SEL_IEN:  rd_mux = ien_q;
      SEL_LVL:  rd_mux = lvl_rd;
      SEL_TRI:  rd_mux = tri_q;
      SEL_INV:  rd_mux = inv_q;
      SEL_DIR:  rd_mux = dir_q;
      SEL_ODR:  rd_mux = odr_q;
      SEL_STAT: rd_mux = sticky;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rvalid   <= 1'b0;
      clr_mask <= '0;
    end else begin
      rvalid   <= rd_en;
      clr_mask <= (rd_en && sel == SEL_STAT) ? sticky : '0;
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/pinbank_edge.sv
module pinbank_edge #(
  parameter int NPIN = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] lvl_eff,
  input  logic [NPIN-1:0] is_in,
  input  logic [NPIN-1:0] ien,
  input  logic            reload,
  input  logic [NPIN-1:0] clr_mask,
  output logic [NPIN-1:0] sticky,
  output logic            irq
);
  logic [NPIN-1:0] prev;
  logic [NPIN-1:0] rise;

  assign rise = lvl_eff & ~prev & is_in & ien & {NPIN{~reload}};

  always_ff @(posedge clk) begin
    if (rst) begin
      prev   <= '0;
      sticky <= '0;
      irq    <= 1'b0;
    end else begin
      prev   <= lvl_eff;
      sticky <= (sticky & ~clr_mask) | rise;
      irq    <= |(sticky & ien);
    end
  end
endmodule

// File: rtl/pinbank_drive.sv
module pinbank_drive #(
  parameter int NPIN = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] dir_q,
  input  logic [NPIN-1:0] tri_q,
  input  logic [NPIN-1:0] odr_q,
  input  logic [NPIN-1:0] lvl_q,
  input  logic            timer_sel,
  input  logic            timer_out,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe
);
  genvar i;
  generate
    for (i = 0; i < NPIN; i++) begin : g_pin
      logic out_n, oe_n;
      always_comb begin
        if (dir_q[i] || tri_q[i]) begin
          out_n = 1'b0;
          oe_n  = 1'b0;
        end else if (odr_q[i]) begin
          out_n = 1'b0;
          oe_n  = ~lvl_q[i];
        end else begin
          out_n = lvl_q[i];
          oe_n  = 1'b1;
        end
      end
      if (i == 0) begin : g_timer
        always_ff @(posedge clk) begin
          if (rst) begin
            pad_out[i] <= 1'b0;
            pad_oe[i]  <= 1'b0;
          end else if (timer_sel) begin
            pad_out[i] <= timer_out;
            pad_oe[i]  <= 1'b1;
          end else begin
            pad_out[i] <= out_n;
            pad_oe[i]  <= oe_n;
          end
        end
      end else begin : g_plain
        always_ff @(posedge clk) begin
          if (rst) begin
            pad_out[i] <= 1'b0;
            pad_oe[i]  <= 1'b0;
          end else begin
            pad_out[i] <= out_n;
            pad_oe[i]  <= oe_n;
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/pinbank_top.sv
module pinbank_top
  import pinbank_pkg::*;
#(
  parameter int NPIN        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPIN-1:0]   wdata,
  output logic [NPIN-1:0]   rdata,
  output logic              rvalid,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  input  logic              timer_out,
  input  logic              timer_sel,
  output logic              irq
);
  logic [NPIN-1:0] ien_q, lvl_q, tri_q, inv_q, dir_q, odr_q;
  logic [NPIN-1:0] pad_sync, timer_own, lvl_eff, is_in, lvl_rd;
  logic [NPIN-1:0] sticky, clr_mask;
  logic            cfg_chg, tsel_q, reload;

  assign timer_own = {{(NPIN-1){1'b0}}, timer_sel};
  assign lvl_eff   = pad_sync ^ (inv_q & ~timer_own);
  assign is_in     = dir_q & ~timer_own;
  assign lvl_rd    = (is_in & lvl_eff) | (~is_in & lvl_q);
  assign reload    = cfg_chg | (timer_sel ^ tsel_q);

  always_ff @(posedge clk) begin
    if (rst) tsel_q <= 1'b0;
    else     tsel_q <= timer_sel;
  end

  pinbank_sync #(.NPIN(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pad_sync)
  );

  pinbank_regs #(.NPIN(NPIN)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .lvl_rd(lvl_rd), .sticky(sticky),
    .ien_q(ien_q), .lvl_q(lvl_q), .tri_q(tri_q), .inv_q(inv_q),
    .dir_q(dir_q), .odr_q(odr_q), .cfg_chg(cfg_chg), .clr_mask(clr_mask),
    .rdata(rdata), .rvalid(rvalid)
  );

  pinbank_edge #(.NPIN(NPIN)) u_edge (
    .clk(clk), .rst(rst), .lvl_eff(lvl_eff), .is_in(is_in), .ien(ien_q),
    .reload(reload), .clr_mask(clr_mask), .sticky(sticky), .irq(irq)
  );

  pinbank_drive #(.NPIN(NPIN)) u_drive (
    .clk(clk), .rst(rst), .dir_q(dir_q), .tri_q(tri_q), .odr_q(odr_q),
    .lvl_q(lvl_q), .timer_sel(timer_sel), .timer_out(timer_out),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );
endmodule

// File: rtl/pinbank_chk.sv
module pinbank_chk #(
  parameter int NPIN = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            rd_en,
  input logic            rvalid,
  input logic            timer_sel,
  input logic            timer_out,
  input logic [NPIN-1:0] pad_out,
  input logic [NPIN-1:0] pad_oe,
  input logic [NPIN-1:0] odr_q,
  input logic [NPIN-1:0] tri_q,
  input logic [NPIN-1:0] sticky,
  input logic [NPIN-1:0] ien_q,
  input logic            irq
);
  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid); // R2
  AST_RVALID_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> $past(rd_en)); // R2
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(sticky & ien_q))); // R9
  AST_TIMER_ON_PIN0: assert property (@(posedge clk) disable iff (rst)
    $past(timer_sel) |-> (pad_oe[0] && pad_out[0] == $past(timer_out))); // R11

  genvar i;
  generate
    for (i = 1; i < NPIN; i++) begin : g_pin
      AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (rst)
        (pad_oe[i] && pad_out[i]) |-> !$past(odr_q[i])); // R5
      AST_TRI_RELEASES: assert property (@(posedge clk) disable iff (rst)
        $past(tri_q[i]) |-> !pad_oe[i]); // R6
    end
  endgenerate
endmodule

bind pinbank_top pinbank_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rvalid(rvalid),
  .timer_sel(timer_sel), .timer_out(timer_out), .pad_out(pad_out),
  .pad_oe(pad_oe), .odr_q(odr_q), .tri_q(tri_q), .sticky(sticky),
  .ien_q(ien_q), .irq(irq)
);

// File: tb/tb_pinbank_top.sv
`timescale 1ns/1ps
module tb_pinbank_top;
  localparam int NPIN = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]      addr = '0;
  logic [NPIN-1:0] wdata = '0, pad_in = '0;
  logic            timer_out = 1'b0, timer_sel = 1'b0;
  logic [NPIN-1:0] rdata, pad_out, pad_oe;
  logic            rvalid, irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [NPIN-1:0] exp_q [$];
  string           tag_q [$];

  always #4 clk = ~clk;

  pinbank_top #(.NPIN(NPIN)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .timer_out(timer_out),
    .timer_sel(timer_sel), .irq(irq)
  );

  task automatic check(input string tag, input logic [NPIN-1:0] act,
                       input logic [NPIN-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [NPIN-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [NPIN-1:0] e,
                    input string tag);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  // monitor: pops expected read data as rvalid appears
  always @(negedge clk) begin
    if (!rst && rvalid) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R2 unexpected rvalid actual=%h expected=none", rdata);
      end else begin
        logic [NPIN-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rdata, e);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_checks++; n_fail++;
          $display("FAIL watchdog actual=hung expected=finished");
          $display("End of test - %0d assertions evaluated, %0d failures",
                   n_checks, n_fail);
          $finish;
        end
      end
    join_none

    step(4);
    rst = 1'b0;
    step(1);
    check("R1 pad_oe after reset", pad_oe, 16'h0000);
    check("R1 irq after reset", {15'd0, irq}, 16'h0000);
    rd(3'd4, 16'hFFFF, "R1 direction reset");
    rd(3'd0, 16'h0000, "R1 enable reset");
    rd(3'd5, 16'h0000, "R1 open-drain reset");

    wr(3'd0, 16'hA5A5); wr(3'd2, 16'h1234); wr(3'd3, 16'h0F0F); wr(3'd5, 16'h00FF);
    rd(3'd0, 16'hA5A5, "R2 enable readback");
    rd(3'd2, 16'h1234, "R2 3-state readback");
    rd(3'd3, 16'h0F0F, "R2 invert readback");
    rd(3'd5, 16'h00FF, "R2 open-drain readback");
    rd(3'd7, 16'h0000, "R12 address 7 reads zero");
    wr(3'd0, 16'h0000); wr(3'd2, 16'h0000); wr(3'd3, 16'h0000); wr(3'd5, 16'h0000);

    // outputs
    wr(3'd1, 16'hF00F); wr(3'd4, 16'h0000); step(2);
    check("R4 push-pull oe", pad_oe, 16'hFFFF);
    check("R4 push-pull out", pad_out, 16'hF00F);
    rd(3'd1, 16'hF00F, "R3 output pins read stored level");
    wr(3'd5, 16'hFF00); step(2);
    check("R5 open-drain oe", pad_oe, 16'h0FFF);
    check("R5 open-drain out", pad_out, 16'h000F);
    wr(3'd2, 16'h00F0); step(2);
    check("R6 3-state oe", pad_oe, 16'h0F0F);
    check("R6 3-state out", pad_out, 16'h000F);

    // inputs
    wr(3'd4, 16'hFFFF); wr(3'd2, 16'h0000); wr(3'd5, 16'h0000); step(2);
    check("R6 input pins released", pad_oe, 16'h0000);
    pad_in = 16'h00AA;
    wr(3'd3, 16'h000F); step(4);
    rd(3'd1, 16'h00A5, "R3 input level after inversion");
    rd(3'd6, 16'h0000, "R8 status empty");

    // edges
    wr(3'd0, 16'h00F0);
    pad_in = 16'h01FA; step(5);
    check("R9 irq on enabled flag", {15'd0, irq}, 16'h0001);
    rd(3'd6, 16'h0050, "R7 rising edges on enabled pins");
    step(2);
    rd(3'd6, 16'h0000, "R8 status cleared after read");
    step(2);
    check("R9 irq low after clear", {15'd0, irq}, 16'h0000);
    pad_in = 16'h01EA; step(5);
    check("R7 falling edge sets nothing", {15'd0, irq}, 16'h0000);
    wr(3'd0, 16'h00F1);
    pad_in = 16'h01EB; step(5);
    check("R7 inverted fall sets nothing", {15'd0, irq}, 16'h0000);
    pad_in = 16'h01EA; step(5);
    rd(3'd6, 16'h0001, "R7 inverted rise sets flag");
    rd(3'd6, 16'h0000, "R8 status cleared");

    // irq masking
    pad_in = 16'h01AA; step(4);
    pad_in = 16'h01EA; step(5);
    check("R9 irq set by bit 6", {15'd0, irq}, 16'h0001);
    wr(3'd0, 16'h00B1); step(3);
    check("R9 irq masked by enable", {15'd0, irq}, 16'h0000);
    wr(3'd0, 16'h00F1); step(3);
    check("R9 irq returns with enable", {15'd0, irq}, 16'h0001);
    rd(3'd6, 16'h0040, "R9 flag kept while masked");
    step(3);

    // configuration changes
    wr(3'd3, 16'h002F); step(4);
    wr(3'd3, 16'h000F); step(5);
    check("R10 invert change no irq", {15'd0, irq}, 16'h0000);
    rd(3'd6, 16'h0000, "R10 invert change no flag");
    wr(3'd4, 16'hFF7F); step(4);
    wr(3'd4, 16'hFFFF); step(5);
    rd(3'd6, 16'h0000, "R10 direction change no flag");

    // timer override
    timer_sel = 1'b1; timer_out = 1'b1; step(2);
    check("R11 timer drives pin 0 high", pad_out & 16'h0001, 16'h0001);
    check("R11 only pin 0 enabled", pad_oe, 16'h0001);
    timer_out = 1'b0; step(2);
    check("R11 timer drives pin 0 low", pad_out & 16'h0001, 16'h0000);
    pad_in = 16'h01EB; step(5);
    rd(3'd6, 16'h0000, "R11 pin 0 under timer sets no flag");
    timer_sel = 1'b0; step(5);
    rd(3'd6, 16'h0000, "R11 leaving timer mode sets no flag");

    // ignored writes
    wr(3'd6, 16'hFFFF); wr(3'd7, 16'hFFFF); step(3);
    rd(3'd6, 16'h0000, "R12 status write ignored");
    rd(3'd7, 16'h0000, "R12 address 7 write ignored");
    check("R12 irq unaffected", {15'd0, irq}, 16'h0000);

    step(3);
    if (exp_q.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL R2 missing reads actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_checks, n_fail);
    $finish;
  end
endmodule